// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries a 32-bit core with user and kernel privilege through the register updates needed to enter an interrupt handler. When a request arrives with the interrupt-enable flag set, it takes a snapshot of the vector, the status word, the program counter, both stack pointers and the exception base. It then walks a fixed sequence of single-cycle write strobes toward the core's register file. Finally it fetches the handler address from a vector table in memory and loads it into the program counter.

Every register update is a write-enable strobe with its value beside it, so the core decides how each write lands. The vector table is read through a valid/ready request channel, and the response carries an error bit. `busy` marks the whole sequence. `done` pulses once in the last cycle, together with either the program-counter write or `err`.

Top module: `irq_entry_seq`

## Requirements
- R1: While `ie_flag` is low, a request leaves `busy` low and raises no write strobe and no memory request.
- R2: The status write value is `((old << 10) & 32'h3FFF_FFFF) | (old & 32'h8000_0000)`: bit 31 is kept, bit 30 and bits 9:0 are zero, and old bits 19:0 move to bits 29:10.
- R3: `user_clr` pulses alone, in an earlier cycle than every other write strobe of the sequence.
- R4: If `user_flag` was set at acceptance, `usp_we` and `sp_we` pulse together, carrying the old stack pointer and the kernel stack pointer respectively. If it was clear, neither pulses.
- R5: `erp_we` pulses once and carries the program counter captured at acceptance.
- R6: `exs_we` pulses once with vector × 256, and `eda_clr` pulses once to clear the exception data address.
- R7: The table read address is `ebase_in + 4 × vector`. Response byte lane k (bits 8k+7:8k) holds the byte at address+k, so the handler address is assembled little-endian, and `pc_out` carries it with `pc_we`.
- R8: A response with `mem_rsp_err` set gives no `pc_we`. Instead `err` pulses with `done`.
- R9: `mem_req_valid` stays high, with `mem_req_addr` unchanged, until `mem_req_ready` is seen. The response may come in the same cycle as ready or in any later cycle.
- R10: `busy` is high from the cycle after acceptance until the cycle that carries `done`, which pulses once per sequence. Requests and vector changes during `busy` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request level |
| irq_vec | input | 8 | Interrupt vector number |
| ie_flag | input | 1 | Interrupt enable flag of the core |
| user_flag | input | 1 | Core is in user mode |
| status_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Saved kernel stack pointer |
| ebase_in | input | 32 | Exception vector table base |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of the sequence |
| err | output | 1 | Vector fetch failed, PC not written |
| user_clr | output | 1 | Clear the user-mode flag |
| status_we | output | 1 | Write status word |
| status_out | output | 32 | New status word |
| usp_we | output | 1 | Write user stack save register |
| usp_out | output | 32 | Value for user stack save register |
| sp_we | output | 1 | Write stack pointer |
| sp_out | output | 32 | New stack pointer |
| erp_we | output | 1 | Write return-address register |
| erp_out | output | 32 | Return address |
| exs_we | output | 1 | Write exception-status register |
| exs_out | output | 32 | Exception status value |
| eda_clr | output | 1 | Clear exception data address register |
| pc_we | output | 1 | Write program counter |
| pc_out | output | 32 | Handler address |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Table read request accepted |
| mem_req_addr | output | 32 | Table read address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data, little-endian lanes |
| mem_rsp_err | input | 1 | Read response error |

## Verification
Request acceptance and response delivery can fall in the same cycle. The bench's memory model uses a latency of zero for one vector in four, raising ready and the response together, and latencies of one to three for the rest. In every case the bench judges the handler address and the single `done` against the arithmetic table contents. A new request, and a vector that changes while `busy` is high, also coincide with the running sequence. They are shown to have no effect when exactly one `done` appears and the exception status carries the vector that was accepted.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             ie_flag,
  input  logic             user_flag,
  input  logic [31:0]      status_in,
  input  logic [31:0]      pc_in,
  input  logic [31:0]      sp_in,
  input  logic [31:0]      ksp_in,
  input  logic [31:0]      ebase_in,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             user_clr,
  output logic             status_we,
  output logic [31:0]      status_out,
  output logic             usp_we,
  output logic [31:0]      usp_out,
  output logic             sp_we,
  output logic [31:0]      sp_out,
  output logic             erp_we,
  output logic [31:0]      erp_out,
  output logic             exs_we,
  output logic [31:0]      exs_out,
  output logic             eda_clr,
  output logic             pc_we,
  output logic [31:0]      pc_out,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [31:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  input  logic             mem_rsp_err
);
  localparam int EXS_PAD = 32 - VEC_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_MODE, S_SAVE, S_SWAP, S_RREQ, S_RWAIT, S_LOAD} st_t;
  st_t state;

  logic [VEC_W-1:0] vec_q;
  logic [31:0]      st_q, pc_q, sp_q, ksp_q, addr_q, data_q;
  logic             user_q, err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      vec_q  <= '0;
      st_q   <= '0;
      pc_q   <= '0;
      sp_q   <= '0;
      ksp_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      user_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (irq_req && ie_flag) begin
          vec_q  <= irq_vec;
          st_q   <= status_in;
          pc_q   <= pc_in;
          sp_q   <= sp_in;
          ksp_q  <= ksp_in;
          user_q <= user_flag;
          addr_q <= ebase_in + {{(30-VEC_W){1'b0}}, irq_vec, 2'b00};
          state  <= S_MODE;
        end
        S_MODE: state <= S_SAVE;
        S_SAVE: state <= user_q ? S_SWAP : S_RREQ;
        S_SWAP: state <= S_RREQ;
        S_RREQ: if (mem_req_ready) begin
          if (mem_rsp_valid) begin
            data_q <= mem_rsp_data;
            err_q  <= mem_rsp_err;
            state  <= S_LOAD;
          end else begin
            state  <= S_RWAIT;
          end
        end
        S_RWAIT: if (mem_rsp_valid) begin
          data_q <= mem_rsp_data;
          err_q  <= mem_rsp_err;
          state  <= S_LOAD;
        end
        S_LOAD: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy          = state != S_IDLE;
  assign user_clr      = state == S_MODE;
  assign status_we     = state == S_SAVE;
  assign erp_we        = state == S_SAVE;
  assign exs_we        = state == S_SAVE;
  assign eda_clr       = state == S_SAVE;
  assign usp_we        = state == S_SWAP;
  assign sp_we         = state == S_SWAP;
  assign mem_req_valid = state == S_RREQ;
  assign done          = state == S_LOAD;
  assign pc_we         = done && !err_q;
  assign err           = done && err_q;

  assign status_out   = {st_q[31], 1'b0, st_q[19:0], 10'b0};
  assign usp_out      = sp_q;
  assign sp_out       = ksp_q;
  assign erp_out      = pc_q;
  assign exs_out      = {{EXS_PAD{1'b0}}, vec_q, 8'b0};
  assign pc_out       = data_q;
  assign mem_req_addr = addr_q;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_req,
  input logic        ie_flag,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        user_clr,
  input logic        status_we,
  input logic [31:0] status_out,
  input logic        usp_we,
  input logic        sp_we,
  input logic        erp_we,
  input logic        exs_we,
  input logic [31:0] exs_out,
  input logic        eda_clr,
  input logic        pc_we,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr
);
  logic any_wr;
  assign any_wr = status_we || usp_we || sp_we || erp_we || exs_we || eda_clr || pc_we;

  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && irq_req && !ie_flag) |=> !busy); // R1
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_we |-> (status_out[9:0] == 10'd0 && !status_out[30])); // R2
  AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    user_clr |-> !any_wr); // R3
  AST_CLEAR_BEFORE_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    status_we |-> $past(user_clr)); // R3
  AST_SWAP_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    usp_we |-> sp_we); // R4
  AST_EXS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    exs_we |-> exs_out[7:0] == 8'd0); // R6
  AST_PC_OR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_we && err)); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R10
  AST_WRITES_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr || user_clr || mem_req_valid) |-> busy); // R10
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (.*);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, irq_req, ie_flag, user_flag;
  logic [7:0] irq_vec;
  logic [31:0] status_in, pc_in, sp_in, ksp_in, ebase_in;
  logic busy, done, err, user_clr, status_we, usp_we, sp_we, erp_we, exs_we, eda_clr, pc_we;
  logic [31:0] status_out, usp_out, sp_out, erp_out, exs_out, pc_out, mem_req_addr;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_data;

  irq_entry_seq uut (.*);

  int checks = 0, errors = 0;
  int mlat = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] tbyte(input logic [31:0] a);
    return 8'(a * 32'd7 + 32'd3);
  endfunction

  logic [31:0] limit_addr;
  int mphase = 0, mcnt = 0;
  logic [31:0] maddr;
  initial begin mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0; mem_rsp_err = 0; end
  always @(negedge clk) begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    if (mphase == 0 && mem_req_valid) begin
      maddr = mem_req_addr;
      mem_req_ready = 1'b1;
      mem_rsp_data = {tbyte(maddr+3), tbyte(maddr+2), tbyte(maddr+1), tbyte(maddr)};
      mem_rsp_err = (maddr >= limit_addr);
      if (mlat == 0) mem_rsp_valid = 1'b1;
      else begin mphase = 1; mcnt = mlat; end
    end else if (mphase == 1) begin
      if (mem_req_valid) chk(mem_req_addr == maddr, "R9 addr stable", mem_req_addr, maddr);
      if (mcnt == 1) begin mem_rsp_valid = 1'b1; mphase = 0; end
      else mcnt--;
    end
  end

  task automatic run_one(input logic [7:0] v, input logic [31:0] st, input bit usr, input int lat);
    logic [31:0] st_exp, pc_exp, addr_exp;
    bit err_exp;
    int cyc = 0, first_clr = 0, first_other = 0;
    int n_done = 0, n_pc = 0, n_err = 0, n_swap = 0, n_stat = 0, n_eda = 0, n_erp = 0, n_exs = 0;
    st_exp   = ((st << 10) & 32'h3FFF_FFFF) | (st & 32'h8000_0000);
    addr_exp = ebase_in + 32'(v) * 4;
    pc_exp   = 32'(tbyte(addr_exp)) | (32'(tbyte(addr_exp+1)) << 8) |
               (32'(tbyte(addr_exp+2)) << 16) | (32'(tbyte(addr_exp+3)) << 24);
    err_exp  = addr_exp >= limit_addr;
    mlat = lat;
    irq_vec = v; status_in = st; user_flag = usr;
    pc_in = {v, 8'h10, ~v, 8'h02}; sp_in = {16'h7000, v, 8'h00}; ksp_in = {16'h8000, ~v, 8'hF0};
    irq_req = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        chk(busy, "R10 busy after accept", 32'(busy), 1);
        irq_vec = ~v;
      end
      if (user_clr && first_clr == 0) first_clr = cyc;
      if ((status_we || usp_we || sp_we || erp_we || exs_we || eda_clr || pc_we) && first_other == 0) first_other = cyc;
      if (status_we) begin n_stat++; chk(status_out == st_exp, "R2 status", status_out, st_exp); end
      if (erp_we) begin n_erp++; chk(erp_out == pc_in, "R5 return address", erp_out, pc_in); end
      if (exs_we) begin n_exs++; chk(exs_out == 32'(v) * 256, "R6 exception status", exs_out, 32'(v) * 256); end
      if (eda_clr) n_eda++;
      if (usp_we) begin
        n_swap++;
        chk(usp_out == sp_in, "R4 user stack save", usp_out, sp_in);
        chk(sp_we && sp_out == ksp_in, "R4 kernel stack load", sp_out, ksp_in);
      end
      if (mem_req_valid) chk(mem_req_addr == addr_exp, "R7 table address", mem_req_addr, addr_exp);
      if (pc_we) begin n_pc++; chk(pc_out == pc_exp, "R7 handler address", pc_out, pc_exp); end
      if (err) n_err++;
      if (done) begin n_done++; irq_req = 1'b0; break; end
    end
    irq_req = 1'b0;
    @(negedge clk);
    chk(!busy, "R10 idle after done", 32'(busy), 0);
    chk(n_done == 1, "R10 one done", n_done, 1);
    chk(first_clr > 0 && first_clr < first_other, "R3 user cleared first", first_clr, first_other);
    chk(n_swap == int'(usr), "R4 swap only from user", n_swap, int'(usr));
    chk(n_stat == 1 && n_erp == 1, "R5 single save", n_erp, 1);
    chk(n_exs == 1 && n_eda == 1, "R6 single exs and eda clear", n_eda, 1);
    chk(n_pc == int'(!err_exp), "R8 pc write", n_pc, int'(!err_exp));
    chk(n_err == int'(err_exp), "R8 error pulse", n_err, int'(err_exp));
  endtask

  initial begin
    rst_n = 0; irq_req = 0; irq_vec = 0; ie_flag = 1; user_flag = 0;
    status_in = 0; pc_in = 0; sp_in = 0; ksp_in = 0;
    ebase_in = 32'h0001_0000; limit_addr = 32'h0001_0000 + 32'd800;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_req_valid && !user_clr, "R10 reset state", 32'(busy), 0);

    ie_flag = 0; irq_req = 1; irq_vec = 8'h21; user_flag = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!busy && !mem_req_valid && !user_clr && !status_we && !sp_we && !pc_we,
          "R1 disabled request ignored", 32'(busy), 0);
    end
    irq_req = 0; ie_flag = 1;
    @(negedge clk);

    for (int pass = 0; pass < 2; pass++)
      for (int v = 0; v < 256; v++) begin
        logic [31:0] st;
        st = {v[7:0], ~v[7:0], v[7:0] ^ 8'h5A, v[7:0] ^ 8'hC3};
        if (pass == 1) st = ~st;
        run_one(8'(v), st, v[0] ^ pass[0], (v + pass) % 4);
      end

    ebase_in = 32'hFFFF_FF00; limit_addr = 32'hFFFF_FFFF;
    run_one(8'h3F, 32'h8000_0001, 1'b1, 0);
    run_one(8'h3F, 32'h4000_0000, 1'b0, 2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule